// File: doc/BRIEF.md
# Half-Precision Classify, Sign-Inject and Min/Max Unit

This unit handles the non-arithmetic binary16 floating-point operations of a scalar FPU: sorting an operand into one of ten value categories, building a result from one operand's magnitude and a sign derived from both operands, and choosing the smaller or larger of two operands with IEEE 754-2019 minimum/maximum-number semantics. Operands arrive as bare 16-bit encodings with a 3-bit operation code and an input valid strobe.

Each request is captured in a single output register stage, so the result appears one clock after the request. The 64-bit result carries either the 16-bit floating-point value or the 10-bit category mask, zero-extended in both cases. An invalid-operation flag travels with the result. The rest of the FPU handles NaN boxing, rounding and exception accumulation.

Top module: `hfp_misc_unit`

## Requirements
- R1: With op code 3'b101 (classify), operand A that is not a NaN sets exactly one mask bit. Positive values use bit 4 for zero, bit 5 for subnormal, bit 6 for normal and bit 7 for infinity. Negative values use bit 3 for zero, bit 2 for subnormal, bit 1 for normal and bit 0 for infinity. An exponent field of all ones with zero fraction is infinity. An exponent field of zero is zero or subnormal, split by the fraction.
- R2: With op code 3'b101, a NaN operand A sets only bit 8 when signaling (fraction bit 9 clear) and only bit 9 when quiet, whatever its sign. Result bits 63..10 are zero for every classify.
- R3: Op codes 3'b000, 3'b001 and 3'b010 return bits 14..0 of A unchanged, NaN payloads included. The sign bit is B's sign for 3'b000, the inverted sign of B for 3'b001 and the XOR of both signs for 3'b010. Result bits 63..16 are zero.
- R4: Op code 3'b011 (minimum) returns A when A is ordered-less than B, or when the two compare equal and A is negative, so -0 beats +0. Otherwise it returns B.
- R5: Op code 3'b100 (maximum) returns A when B is ordered-less than A, or when the two compare equal and B is negative, so +0 beats -0. Otherwise it returns B.
- R6: For minimum and maximum, a single NaN operand yields the other operand. Two NaN operands yield the canonical NaN 16'h7E00.
- R7: The invalid flag is set only by minimum or maximum with a signaling-NaN operand. Classify and sign injection never set it.
- R8: The result, flag and out_valid change on the first rising clock edge after a cycle with in_valid high. While in_valid is low, out_valid is low and the result and flag hold.
- R9: While reset is asserted, out_valid, the result and the flag are all zero. Reset acts at once when asserted and is released on a clock edge.
- R10: Op codes 3'b110 and 3'b111 return a zero result with the flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 3 | Operation code |
| in_a | input | 16 | Operand A, binary16 |
| in_b | input | 16 | Operand B, binary16 |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_result | output | 64 | Zero-extended FP result or category mask |
| out_invalid | output | 1 | Invalid-operation flag |

## Verification
The only internal state is the output register and the reset synchronizer. A wrong captured value therefore shows at the ports on the very cycle after its request. The register then holds it until the next valid request, so it cannot hide behind later idle cycles. Decode faults are combinational and show up only for particular operand classes. The vectors therefore cover every category on both signs and both NaN kinds. They also cover signed zeros in either operand order, and same-sign negatives where the magnitude order reverses.

// File: rtl/hfp_pkg.sv
package hfp_pkg;

  // operation codes seen on in_op
  localparam logic [2:0] OPC_SGNJ  = 3'b000;
  localparam logic [2:0] OPC_SGNJN = 3'b001;
  localparam logic [2:0] OPC_SGNJX = 3'b010;
  localparam logic [2:0] OPC_MIN   = 3'b011;
  localparam logic [2:0] OPC_MAX   = 3'b100;
  localparam logic [2:0] OPC_CLASS = 3'b101;

  localparam int CLASS_W = 10;

  // category bit positions of the classify mask
  localparam int CB_NINF  = 0;
  localparam int CB_NNORM = 1;
  localparam int CB_NSUB  = 2;
  localparam int CB_NZERO = 3;
  localparam int CB_PZERO = 4;
  localparam int CB_PSUB  = 5;
  localparam int CB_PNORM = 6;
  localparam int CB_PINF  = 7;
  localparam int CB_SNAN  = 8;
  localparam int CB_QNAN  = 9;

  typedef struct packed {
    logic sign;
    logic is_inf;
    logic is_nan;
    logic is_snan;
    logic is_zero;
    logic is_sub;
    logic is_norm;
  } hfp_kind_t;

endpackage

// File: rtl/hfp_kind_decode.sv
module hfp_kind_decode
  import hfp_pkg::*;
#(
  parameter int EXP_W = 5,
  parameter int MAN_W = 10
) (
  input  logic [EXP_W+MAN_W:0] val_i,
  output hfp_kind_t            kind_o
);
  localparam int FP_W = EXP_W + MAN_W + 1;

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] frac_f;
  logic             exp_max, exp_min, frac_nz;

  assign exp_f   = val_i[FP_W-2:MAN_W];
  assign frac_f  = val_i[MAN_W-1:0];
  assign exp_max = &exp_f;
  assign exp_min = ~|exp_f;
  assign frac_nz = |frac_f;

  always_comb begin
    kind_o         = '0;
    kind_o.sign    = val_i[FP_W-1];
    kind_o.is_inf  = exp_max & ~frac_nz;
    kind_o.is_nan  = exp_max & frac_nz;
    kind_o.is_snan = exp_max & frac_nz & ~frac_f[MAN_W-1];
    kind_o.is_zero = exp_min & ~frac_nz;
    kind_o.is_sub  = exp_min & frac_nz;
    kind_o.is_norm = ~exp_max & ~exp_min;
  end

endmodule

// File: rtl/hfp_sign_inject.sv
module hfp_sign_inject
  import hfp_pkg::*;
#(
  parameter int FP_W = 16
) (
  input  logic [FP_W-1:0] a_i,
  input  logic [FP_W-1:0] b_i,
  input  logic [2:0]      op_i,
  output logic [FP_W-1:0] y_o
);
  logic new_sign;

  always_comb begin
    unique case (op_i)
      OPC_SGNJN: new_sign = ~b_i[FP_W-1];
      OPC_SGNJX: new_sign = a_i[FP_W-1] ^ b_i[FP_W-1];
      default:   new_sign = b_i[FP_W-1];
    endcase
    y_o = {new_sign, a_i[FP_W-2:0]};
  end

endmodule

// File: rtl/hfp_minmax.sv
module hfp_minmax
  import hfp_pkg::*;
#(
  parameter int EXP_W = 5,
  parameter int MAN_W = 10
) (
  input  logic [EXP_W+MAN_W:0] a_i,
  input  logic [EXP_W+MAN_W:0] b_i,
  input  hfp_kind_t            ka_i,
  input  hfp_kind_t            kb_i,
  input  logic                 want_max_i,
  output logic [EXP_W+MAN_W:0] y_o,
  output logic                 invalid_o
);
  localparam int FP_W  = EXP_W + MAN_W + 1;
  localparam int MAG_W = FP_W - 1;
  localparam logic [FP_W-1:0] CANON_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic [MAG_W-1:0] mag_a, mag_b;
  logic             any_nan, both_nan;
  logic             a_lt_b, b_lt_a, a_eq_b;
  logic             pick_a;

  assign mag_a    = a_i[MAG_W-1:0];
  assign mag_b    = b_i[MAG_W-1:0];
  assign any_nan  = ka_i.is_nan | kb_i.is_nan;
  assign both_nan = ka_i.is_nan & kb_i.is_nan;

  // ordered comparison: unordered (any NaN) is never less nor equal
  always_comb begin
    a_lt_b = 1'b0;
    b_lt_a = 1'b0;
    a_eq_b = 1'b0;
    if (!any_nan) begin
      if (ka_i.is_zero && kb_i.is_zero) begin
        a_eq_b = 1'b1;
      end else if (ka_i.sign != kb_i.sign) begin
        a_lt_b = ka_i.sign;
        b_lt_a = kb_i.sign;
      end else if (mag_a == mag_b) begin
        a_eq_b = 1'b1;
      end else if (ka_i.sign) begin
        a_lt_b = mag_a > mag_b;
        b_lt_a = mag_b > mag_a;
      end else begin
        a_lt_b = mag_a < mag_b;
        b_lt_a = mag_b < mag_a;
      end
    end
  end

  always_comb begin
    if (want_max_i)
      pick_a = b_lt_a | (a_eq_b & kb_i.sign) | kb_i.is_nan;
    else
      pick_a = a_lt_b | (a_eq_b & ka_i.sign) | kb_i.is_nan;
    if (both_nan)
      y_o = CANON_NAN;
    else
      y_o = pick_a ? a_i : b_i;
    invalid_o = ka_i.is_snan | kb_i.is_snan;
  end

endmodule

// File: rtl/hfp_misc_unit.sv
module hfp_misc_unit
  import hfp_pkg::*;
#(
  parameter int EXP_W      = 5,
  parameter int MAN_W      = 10,
  parameter int XLEN       = 64,
  parameter int RST_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [2:0]           in_op,
  input  logic [EXP_W+MAN_W:0] in_a,
  input  logic [EXP_W+MAN_W:0] in_b,
  output logic                 out_valid,
  output logic [XLEN-1:0]      out_result,
  output logic                 out_invalid
);
  localparam int FP_W = EXP_W + MAN_W + 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[RST_STAGES-1];

  // operand decode, one per source
  logic [FP_W-1:0] opnd [2];
  hfp_kind_t       kind [2];

  assign opnd[0] = in_a;
  assign opnd[1] = in_b;

  for (genvar g = 0; g < 2; g++) begin : g_dec
    hfp_kind_decode #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_dec (
      .val_i  (opnd[g]),
      .kind_o (kind[g])
    );
  end

  // category mask of operand A
  logic [CLASS_W-1:0] class_mask;
  always_comb begin
    class_mask           = '0;
    class_mask[CB_NINF]  = kind[0].sign  & kind[0].is_inf;
    class_mask[CB_NNORM] = kind[0].sign  & kind[0].is_norm;
    class_mask[CB_NSUB]  = kind[0].sign  & kind[0].is_sub;
    class_mask[CB_NZERO] = kind[0].sign  & kind[0].is_zero;
    class_mask[CB_PZERO] = ~kind[0].sign & kind[0].is_zero;
    class_mask[CB_PSUB]  = ~kind[0].sign & kind[0].is_sub;
    class_mask[CB_PNORM] = ~kind[0].sign & kind[0].is_norm;
    class_mask[CB_PINF]  = ~kind[0].sign & kind[0].is_inf;
    class_mask[CB_SNAN]  = kind[0].is_snan;
    class_mask[CB_QNAN]  = kind[0].is_nan & ~kind[0].is_snan;
  end

  logic [FP_W-1:0] sgnj_y;
  hfp_sign_inject #(.FP_W(FP_W)) u_sgnj (
    .a_i  (in_a),
    .b_i  (in_b),
    .op_i (in_op),
    .y_o  (sgnj_y)
  );

  logic [FP_W-1:0] mm_y;
  logic            mm_inv;
  hfp_minmax #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_mm (
    .a_i        (in_a),
    .b_i        (in_b),
    .ka_i       (kind[0]),
    .kb_i       (kind[1]),
    .want_max_i (in_op == OPC_MAX),
    .y_o        (mm_y),
    .invalid_o  (mm_inv)
  );

  // next-state selection
  logic [XLEN-1:0] res_d;
  logic            inv_d;

  always_comb begin
    res_d = '0;
    inv_d = 1'b0;
    unique case (in_op)
      OPC_SGNJ, OPC_SGNJN, OPC_SGNJX: res_d[FP_W-1:0] = sgnj_y;
      OPC_MIN, OPC_MAX: begin
        res_d[FP_W-1:0] = mm_y;
        inv_d           = mm_inv;
      end
      OPC_CLASS: res_d[CLASS_W-1:0] = class_mask;
      default: ;
    endcase
  end

  // output register with explicit capture enable
  logic            vld_q, inv_q;
  logic [XLEN-1:0] res_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      inv_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        res_q <= res_d;
        inv_q <= inv_d;
      end
    end
  end

  assign out_valid   = vld_q;
  assign out_result  = res_q;
  assign out_invalid = inv_q;

endmodule

// File: rtl/hfp_misc_unit_chk.sv
module hfp_misc_unit_chk (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        in_valid,
  input logic [2:0]  in_op,
  input logic [15:0] in_a,
  input logic [15:0] in_b,
  input logic        out_valid,
  input logic [63:0] out_result,
  input logic        out_invalid
);

  // R8: a request produces a valid result on the next edge
  p_valid_next_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);

  // R8: idle cycles leave result and flag untouched
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> ($stable(out_result) && $stable(out_invalid) && !out_valid));

  // R1, R2: classify sets exactly one bit, upper bits clear
  p_class_onehot_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_op == 3'b101) |=>
      ($countones(out_result[9:0]) == 1 && out_result[63:10] == '0));

  // R3: sign injection keeps A's magnitude bits
  p_sgnj_body_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_op <= 3'b010) |=>
      (out_result[14:0] == $past(in_a[14:0]) && out_result[63:16] == '0));

  // R6: min/max returns one of the operands or the canonical NaN
  p_minmax_pick_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && (in_op == 3'b011 || in_op == 3'b100)) |=>
      (out_result[63:16] == '0 &&
       (out_result[15:0] == $past(in_a) || out_result[15:0] == $past(in_b) ||
        out_result[15:0] == 16'h7E00)));

  // R7: flag only from min/max
  p_flag_src_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !(in_op == 3'b011 || in_op == 3'b100)) |=> !out_invalid);

  // R10: reserved codes give zero
  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_op[2:1] == 2'b11) |=> (out_result == '0));

endmodule

bind hfp_misc_unit hfp_misc_unit_chk u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .in_valid    (in_valid),
  .in_op       (in_op),
  .in_a        (in_a),
  .in_b        (in_b),
  .out_valid   (out_valid),
  .out_result  (out_result),
  .out_invalid (out_invalid)
);

// File: tb/test_hfp_misc_unit.sv
`timescale 1ns/1ps
module test_hfp_misc_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  in_op;
  logic [15:0] in_a, in_b;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_invalid;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk; // 50 MHz

  hfp_misc_unit i_hfp_misc_unit (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_op (in_op),
    .in_a (in_a), .in_b (in_b), .out_valid (out_valid),
    .out_result (out_result), .out_invalid (out_invalid)
  );

  // {req(4), op(3), a(16), b(16), expected(16), flag(1)}
  localparam int NV = 38;
  localparam logic [55:0] VEC [NV] = '{
    {4'd1, 3'd5, 16'hFC00, 16'h0000, 16'h0001, 1'b0}, // R1 -inf
    {4'd1, 3'd5, 16'hBC00, 16'h0000, 16'h0002, 1'b0}, // R1 -normal
    {4'd1, 3'd5, 16'h8001, 16'h0000, 16'h0004, 1'b0}, // R1 -subnormal
    {4'd1, 3'd5, 16'h8000, 16'h0000, 16'h0008, 1'b0}, // R1 -zero
    {4'd1, 3'd5, 16'h0000, 16'h0000, 16'h0010, 1'b0}, // R1 +zero
    {4'd1, 3'd5, 16'h03FF, 16'h0000, 16'h0020, 1'b0}, // R1 +subnormal
    {4'd1, 3'd5, 16'h7BFF, 16'h0000, 16'h0040, 1'b0}, // R1 +normal
    {4'd1, 3'd5, 16'h7C00, 16'h0000, 16'h0080, 1'b0}, // R1 +inf
    {4'd2, 3'd5, 16'h7C01, 16'h0000, 16'h0100, 1'b0}, // R2 sNaN
    {4'd2, 3'd5, 16'h7E00, 16'h0000, 16'h0200, 1'b0}, // R2 qNaN
    {4'd2, 3'd5, 16'hFD00, 16'h0000, 16'h0100, 1'b0}, // R2 negative sNaN
    {4'd2, 3'd5, 16'hFFFF, 16'h0000, 16'h0200, 1'b0}, // R2 negative qNaN
    {4'd3, 3'd0, 16'h3C00, 16'h8000, 16'hBC00, 1'b0}, // R3 sgnj
    {4'd3, 3'd0, 16'hBC00, 16'h4000, 16'h3C00, 1'b0}, // R3 sgnj
    {4'd3, 3'd1, 16'h3C00, 16'h8000, 16'h3C00, 1'b0}, // R3 sgnjn
    {4'd3, 3'd1, 16'h3C00, 16'h0000, 16'hBC00, 1'b0}, // R3 sgnjn
    {4'd3, 3'd2, 16'hBC00, 16'h8000, 16'h3C00, 1'b0}, // R3 sgnjx
    {4'd3, 3'd2, 16'h3C00, 16'h8000, 16'hBC00, 1'b0}, // R3 sgnjx
    {4'd7, 3'd0, 16'h7C01, 16'h8000, 16'hFC01, 1'b0}, // R7 R3 sNaN payload kept
    {4'd4, 3'd3, 16'h3C00, 16'h4000, 16'h3C00, 1'b0}, // R4
    {4'd4, 3'd3, 16'h4000, 16'h3C00, 16'h3C00, 1'b0}, // R4
    {4'd4, 3'd3, 16'h0000, 16'h8000, 16'h8000, 1'b0}, // R4 -0 wins
    {4'd4, 3'd3, 16'h8000, 16'h0000, 16'h8000, 1'b0}, // R4 -0 wins
    {4'd4, 3'd3, 16'hC000, 16'hBC00, 16'hC000, 1'b0}, // R4 negatives
    {4'd4, 3'd3, 16'hBC00, 16'h3C00, 16'hBC00, 1'b0}, // R4 mixed sign
    {4'd5, 3'd4, 16'h0000, 16'h8000, 16'h0000, 1'b0}, // R5 +0 wins
    {4'd5, 3'd4, 16'h8000, 16'h0000, 16'h0000, 1'b0}, // R5 +0 wins
    {4'd5, 3'd4, 16'hC000, 16'hBC00, 16'hBC00, 1'b0}, // R5 negatives
    {4'd5, 3'd4, 16'h3C00, 16'h4000, 16'h4000, 1'b0}, // R5
    {4'd6, 3'd3, 16'h7E00, 16'h3C00, 16'h3C00, 1'b0}, // R6 A NaN
    {4'd6, 3'd4, 16'hBC00, 16'hFE00, 16'hBC00, 1'b0}, // R6 B NaN
    {4'd6, 3'd3, 16'hFFFF, 16'hFFFF, 16'h7E00, 1'b0}, // R6 both qNaN
    {4'd6, 3'd3, 16'h7E00, 16'h7C01, 16'h7E00, 1'b1}, // R6 both NaN, sNaN
    {4'd7, 3'd4, 16'h7C01, 16'h4000, 16'h4000, 1'b1}, // R7 sNaN in max
    {4'd7, 3'd4, 16'h7C01, 16'hFE00, 16'h7E00, 1'b1}, // R7 both NaN max
    {4'd7, 3'd5, 16'h7C01, 16'h7C01, 16'h0100, 1'b0}, // R7 classify no flag
    {4'd10, 3'd6, 16'h3C00, 16'h4000, 16'h0000, 1'b0}, // R10
    {4'd10, 3'd7, 16'h7C01, 16'h7C01, 16'h0000, 1'b0}  // R10
  };

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin : stim
    logic [63:0] held;
    in_valid = 1'b0; in_op = '0; in_a = '0; in_b = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 valid", {63'd0, out_valid}, 64'd0);
    chk("R9 result", out_result, 64'd0);
    chk("R9 flag", {63'd0, out_invalid}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [55:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[55:52], i);
      drive(v[51:49], v[48:33], v[32:17]);
      chk({tag, " valid"}, {63'd0, out_valid}, 64'd1);
      chk({tag, " result"}, out_result, {48'd0, v[16:1]});
      chk({tag, " flag"}, {63'd0, out_invalid}, {63'd0, v[0]});
    end

    // R8 hold while idle: change inputs with in_valid low
    drive(3'd4, 16'h7C01, 16'h4000);
    held = out_result;
    in_op = 3'd5; in_a = 16'hFC00; in_b = 16'h0000;
    repeat (3) @(negedge clk);
    chk("R8 idle valid", {63'd0, out_valid}, 64'd0);
    chk("R8 idle result", out_result, held);
    chk("R8 idle flag", {63'd0, out_invalid}, 64'd1);

    // R8 back-to-back: second result on the following edge
    @(negedge clk);
    in_valid = 1'b1; in_op = 3'd0; in_a = 16'h3C00; in_b = 16'h8000;
    @(negedge clk);
    chk("R8 b2b first", out_result, 64'h0000_0000_0000_BC00);
    in_op = 3'd5; in_a = 16'h7C00;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 b2b second", out_result, 64'h0000_0000_0000_0080);
    chk("R8 b2b valid", {63'd0, out_valid}, 64'd1);

    // R9 asynchronous reset mid-stream
    drive(3'd3, 16'h7C01, 16'h3C00);
    #3 rst_n = 1'b0;
    #1;
    chk("R9 async valid", {63'd0, out_valid}, 64'd0);
    chk("R9 async result", out_result, 64'd0);
    chk("R9 async flag", {63'd0, out_invalid}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 after release", out_result, 64'd0);
    report();
  end

endmodule